// File: doc/BRIEF.md
# Thirty-Two Pin General-Purpose I/O Bank

This block manages a bank of 32 pads on a small word-addressed register bus. Each pad is owned either by the general-purpose logic or by one of two internal peripheral functions, called A and B. The general-purpose logic can drive a pad, tri-state it, or run it as an open-drain output. Pull-up control, an optional input glitch filter and edge interrupts are also provided per pad.

Software never does a read-modify-write to change a pin attribute. Each attribute has a write-1-to-set register and a write-1-to-clear register. A read-only status word reports its current value. Writing a zero bit to either register leaves that pin unchanged.

Pad levels pass through a two-flop synchroniser and then an optional two-sample filter. The filtered level is what software reads back. Any change of that level, rising or falling, sets a pending bit. The pending word is cleared when it is read. The single interrupt output stays high while a pending bit is set for a pin whose mask bit is also set, so the parent controller can treat it as a level-sensitive source.

Top module: `gpio_bank32`

## Requirements
- R1: After reset, every pin is owned by the general-purpose logic, every pin selects peripheral A, and all pull-ups are on. Drive enables, output data, the filter, open-drain mode and the interrupt mask are all zero. As a result `pad_oe` is 0, `pad_pullup` is all ones and `irq` is 0.
- R2: Each attribute is changed by a write-1-to-set register and a write-1-to-clear register. Only the pins whose bit is 1 in the written word are changed.
- R3: A pin whose ownership bit is 1 drives `pad_out`/`pad_oe` from the general-purpose data and drive-enable words. Otherwise the pin follows `pa_out`/`pa_oe` when its select bit is 0, or `pb_out`/`pb_oe` when its select bit is 1. Word 24 sets the select bit to A (clears it), word 25 sets it to B, and word 26 reads it back.
- R4: A pin in open-drain mode never drives high. Its `pad_out` is 0, and its `pad_oe` is 1 only while its owner drives it with enable 1 and value 0.
- R5: `pad_pullup` equals the pull-up status word (set with word 28, cleared with word 29, read with word 30).
- R6: The pad status word (word 15) shows `pad_in` whatever the pin's owner. With the filter off, a change of `pad_in` appears after the third rising clock edge.
- R7: With a pin's filter bit on (set with word 8, cleared with word 9, read with word 10), a level seen for only one clock sample is ignored. A level held steady is accepted one clock later than with the filter off.
- R8: Every change of the filtered level, rising or falling, sets that pin's bit in the pending word (word 19). This happens on the same clock edge on which the pad status word changes.
- R9: Reading the pending word with `bus_sel` high clears it on the next clock edge. A level change that lands on that same edge stays pending.
- R10: `irq` is high exactly while a pin has both its pending bit and its mask bit set. The mask is set with word 16, cleared with word 17 and read with word 18.
- R11: The words are laid out as follows.
  - Ownership: set word 0, clear word 1, status word 2.
  - Drive enable: set word 4, clear word 5, status word 6.
  - Output data: set word 12, clear word 13, status word 14.
  - Open-drain: set word 20, clear word 21, status word 22.
  - Status words ignore writes, and unmapped words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word index |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for the word at `bus_addr` |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad drive enables |
| pad_pullup | output | 32 | Pad pull-up enables |
| pa_out | input | 32 | Peripheral A output values |
| pa_oe | input | 32 | Peripheral A drive enables |
| pb_out | input | 32 | Peripheral B output values |
| pb_oe | input | 32 | Peripheral B drive enables |
| irq | output | 1 | Bank interrupt, level |

## Verification
The assertions check on every cycle that:
- an open-drain pin never drives a one;
- a bus write changes no attribute bit outside its data word, and no cycle without a write changes any attribute;
- every change of the filtered level is present in the pending word;
- a pending read leaves behind only edges from the same cycle;
- the interrupt is never raised without a mask bit and a pending bit.

Only the bench scenarios can show the rest:
- the exact latency from pad to status, with and without the filter;
- that a one-sample pulse is rejected;
- the read/edge collision;
- the three-way pad ownership for concrete peripheral data.

// File: rtl/gpio_bank32.sv
`timescale 1ns/1ps
module gpio_bank32 #(
  parameter int PINS = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_pullup,
  input  logic [PINS-1:0] pa_out,
  input  logic [PINS-1:0] pa_oe,
  input  logic [PINS-1:0] pb_out,
  input  logic [PINS-1:0] pb_oe,
  output logic            irq
);
  localparam logic [AW-1:0] A_OWN_SET = 0,  A_OWN_CLR = 1,  A_OWN_ST = 2;
  localparam logic [AW-1:0] A_OE_SET  = 4,  A_OE_CLR  = 5,  A_OE_ST  = 6;
  localparam logic [AW-1:0] A_FLT_SET = 8,  A_FLT_CLR = 9,  A_FLT_ST = 10;
  localparam logic [AW-1:0] A_DAT_SET = 12, A_DAT_CLR = 13, A_DAT_ST = 14, A_PAD_ST = 15;
  localparam logic [AW-1:0] A_IM_SET  = 16, A_IM_CLR  = 17, A_IM_ST  = 18, A_PEND   = 19;
  localparam logic [AW-1:0] A_OD_SET  = 20, A_OD_CLR  = 21, A_OD_ST  = 22;
  localparam logic [AW-1:0] A_SEL_A   = 24, A_SEL_B   = 25, A_SEL_ST = 26;
  localparam logic [AW-1:0] A_PU_SET  = 28, A_PU_CLR  = 29, A_PU_ST  = 30;

  logic [PINS-1:0] own_q, oe_q, flt_q, dat_q, imask_q, md_q, sel_q, pu_q;
  logic [PINS-1:0] s1_q, s2_q, s3_q, lvl_q, pend_q;
  logic [PINS-1:0] accept_w, lvl_nx, edge_w, gval, gen;
  logic            wr, rd_pend;

  assign wr      = bus_sel & bus_wr;
  assign rd_pend = bus_sel & ~bus_wr & (bus_addr == A_PEND);

  function automatic logic [PINS-1:0] upd(input logic [PINS-1:0] cur,
                                          input logic set, input logic clr,
                                          input logic [PINS-1:0] m);
    return (cur | (m & {PINS{set}})) & ~(m & {PINS{clr}});
  endfunction

  function automatic logic hit(input logic w, input logic [AW-1:0] a, input logic [AW-1:0] b);
    return w && (a == b);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= '1;
      oe_q    <= '0;
      flt_q   <= '0;
      dat_q   <= '0;
      imask_q <= '0;
      md_q    <= '0;
      sel_q   <= '0;
      pu_q    <= '1;
    end else begin
      own_q   <= upd(own_q,   hit(wr, bus_addr, A_OWN_SET), hit(wr, bus_addr, A_OWN_CLR), bus_wdata);
      oe_q    <= upd(oe_q,    hit(wr, bus_addr, A_OE_SET),  hit(wr, bus_addr, A_OE_CLR),  bus_wdata);
      flt_q   <= upd(flt_q,   hit(wr, bus_addr, A_FLT_SET), hit(wr, bus_addr, A_FLT_CLR), bus_wdata);
      dat_q   <= upd(dat_q,   hit(wr, bus_addr, A_DAT_SET), hit(wr, bus_addr, A_DAT_CLR), bus_wdata);
      imask_q <= upd(imask_q, hit(wr, bus_addr, A_IM_SET),  hit(wr, bus_addr, A_IM_CLR),  bus_wdata);
      md_q    <= upd(md_q,    hit(wr, bus_addr, A_OD_SET),  hit(wr, bus_addr, A_OD_CLR),  bus_wdata);
      sel_q   <= upd(sel_q,   hit(wr, bus_addr, A_SEL_B),   hit(wr, bus_addr, A_SEL_A),   bus_wdata);
      pu_q    <= upd(pu_q,    hit(wr, bus_addr, A_PU_SET),  hit(wr, bus_addr, A_PU_CLR),  bus_wdata);
    end
  end

  assign accept_w = ~flt_q | ~(s2_q ^ s3_q);
  assign lvl_nx   = (lvl_q & ~accept_w) | (s2_q & accept_w);
  assign edge_w   = lvl_nx ^ lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      lvl_q  <= '0;
      pend_q <= '0;
    end else begin
      s1_q   <= pad_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      lvl_q  <= lvl_nx;
      pend_q <= (rd_pend ? '0 : pend_q) | edge_w;
    end
  end

  assign gval       = (own_q & dat_q) | (~own_q & ~sel_q & pa_out) | (~own_q & sel_q & pb_out);
  assign gen        = (own_q & oe_q)  | (~own_q & ~sel_q & pa_oe)  | (~own_q & sel_q & pb_oe);
  assign pad_out    = gval & ~md_q;
  assign pad_oe     = gen & ~(md_q & gval);
  assign pad_pullup = pu_q;
  assign irq        = |(pend_q & imask_q);

  always_comb begin
    case (bus_addr)
      A_OWN_ST: bus_rdata = own_q;
      A_OE_ST:  bus_rdata = oe_q;
      A_FLT_ST: bus_rdata = flt_q;
      A_DAT_ST: bus_rdata = dat_q;
      A_PAD_ST: bus_rdata = lvl_q;
      A_IM_ST:  bus_rdata = imask_q;
      A_PEND:   bus_rdata = pend_q;
      A_OD_ST:  bus_rdata = md_q;
      A_SEL_ST: bus_rdata = sel_q;
      A_PU_ST:  bus_rdata = pu_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank32_chk.sv
`timescale 1ns/1ps
module gpio_bank32_chk #(
  parameter int PINS = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [PINS-1:0] bus_wdata,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_oe,
  input logic            irq,
  input logic [PINS-1:0] md_q,
  input logic [PINS-1:0] oe_q,
  input logic [PINS-1:0] own_q,
  input logic [PINS-1:0] pu_q,
  input logic [PINS-1:0] imask_q,
  input logic [PINS-1:0] pend_q,
  input logic [PINS-1:0] lvl_q,
  input logic [PINS-1:0] edge_w
);
  localparam logic [AW-1:0] PEND_IDX = 19;

  a_r1_reset_values: assert property (@(posedge clk)
    !rst_n |=> (own_q == '1 && pu_q == '1 && oe_q == '0 && md_q == '0 && imask_q == '0));

  a_r2_write_only_marked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && bus_wr) |->
      (((oe_q ^ $past(oe_q)) | (own_q ^ $past(own_q))) & ~$past(bus_wdata)) == '0);

  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && bus_wr) |-> ($stable(oe_q) && $stable(own_q) && $stable(md_q)));

  a_r4_no_high_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (md_q & pad_oe & pad_out) == '0);

  a_r8_edge_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_q ^ $past(lvl_q)) & ~pend_q) == '0);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == PEND_IDX) |=> (pend_q & ~$past(edge_w)) == '0);

  a_r10_irq_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (imask_q != '0 && pend_q != '0));
endmodule

bind gpio_bank32 gpio_bank32_chk #(.PINS(PINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
  .md_q(md_q), .oe_q(oe_q), .own_q(own_q), .pu_q(pu_q), .imask_q(imask_q),
  .pend_q(pend_q), .lvl_q(lvl_q), .edge_w(edge_w)
);

// File: tb/test_gpio_bank32.sv
`timescale 1ns/1ps
module test_gpio_bank32;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe, pad_pullup;
  logic [31:0] pa_out = 32'h00AA0000, pa_oe = 32'h00F00000;
  logic [31:0] pb_out = 32'h55000000, pb_oe = 32'h0F000000;
  logic        irq;
  int          checks = 0, fails = 0;
  bit          done = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  gpio_bank32 i_gpio_bank32 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pullup(pad_pullup), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_out(pb_out), .pb_oe(pb_oe), .irq(irq));

  // op 0 = write, 1 = read-and-compare; fields {op, req, addr, data, expected}
  localparam int NV = 39;
  localparam logic [79:0] VEC [0:NV-1] = '{
    // R1 reset status words
    {4'd1,4'd1,8'd2, 32'h0,32'hFFFFFFFF}, {4'd1,4'd1,8'd6, 32'h0,32'h0},
    {4'd1,4'd1,8'd10,32'h0,32'h0},        {4'd1,4'd1,8'd14,32'h0,32'h0},
    {4'd1,4'd1,8'd18,32'h0,32'h0},        {4'd1,4'd1,8'd22,32'h0,32'h0},
    {4'd1,4'd1,8'd26,32'h0,32'h0},        {4'd1,4'd1,8'd30,32'h0,32'hFFFFFFFF},
    // R2 set/clear pairs on drive enable
    {4'd0,4'd2,8'd4, 32'h0000FFFF,32'h0}, {4'd1,4'd2,8'd6,32'h0,32'h0000FFFF},
    {4'd0,4'd2,8'd4, 32'h00FF0000,32'h0}, {4'd1,4'd2,8'd6,32'h0,32'h00FFFFFF},
    {4'd0,4'd2,8'd5, 32'h0000000F,32'h0}, {4'd1,4'd2,8'd6,32'h0,32'h00FFFFF0},
    {4'd0,4'd2,8'd5, 32'h00000000,32'h0}, {4'd1,4'd2,8'd6,32'h0,32'h00FFFFF0},
    // R11 output data words
    {4'd0,4'd11,8'd12,32'hA5A5A5A5,32'h0},{4'd1,4'd11,8'd14,32'h0,32'hA5A5A5A5},
    {4'd0,4'd11,8'd13,32'h00000005,32'h0},{4'd1,4'd11,8'd14,32'h0,32'hA5A5A5A0},
    // R3 ownership and peripheral select
    {4'd0,4'd3,8'd1, 32'hFF000000,32'h0}, {4'd1,4'd3,8'd2,32'h0,32'h00FFFFFF},
    {4'd0,4'd3,8'd25,32'hF0000000,32'h0}, {4'd1,4'd3,8'd26,32'h0,32'hF0000000},
    {4'd0,4'd3,8'd24,32'h10000000,32'h0}, {4'd1,4'd3,8'd26,32'h0,32'hE0000000},
    // R5 pull-up
    {4'd0,4'd5,8'd29,32'h0000FFFF,32'h0}, {4'd1,4'd5,8'd30,32'h0,32'hFFFF0000},
    // R10 mask
    {4'd0,4'd10,8'd16,32'h00000003,32'h0},{4'd1,4'd10,8'd18,32'h0,32'h00000003},
    {4'd0,4'd10,8'd17,32'h00000001,32'h0},{4'd1,4'd10,8'd18,32'h0,32'h00000002},
    // R11 open-drain words, R7 filter words
    {4'd0,4'd11,8'd20,32'h000000FF,32'h0},{4'd1,4'd11,8'd22,32'h0,32'h000000FF},
    {4'd0,4'd7,8'd8, 32'h00000001,32'h0}, {4'd1,4'd7,8'd10,32'h0,32'h00000001},
    // R11 status write ignored, unmapped word reads zero
    {4'd0,4'd11,8'd2,32'h00000000,32'h0}, {4'd1,4'd11,8'd2,32'h0,32'h00FFFFFF},
    {4'd1,4'd11,8'd3,32'h0,32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [79:0] v;
      v = VEC[i];
      if (v[79:76] == 4'd0) bus_write(v[68:64], v[63:32]);
      else begin
        bus_read(v[68:64], rd);
        check($sformatf("R%0d vector %0d", v[75:72], i), rd, v[31:0]);
      end
    end

    apply_reset();
    #1;
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_pullup", pad_pullup, 32'hFFFFFFFF);
    check("R1 irq", {31'h0, irq}, 32'h0);

    bus_write(5'd1,  32'hFFFF0000);
    bus_write(5'd25, 32'hFF000000);
    bus_write(5'd4,  32'h0000FFFF);
    bus_write(5'd12, 32'h000000FF);
    bus_write(5'd20, 32'h0000000F);
    #1;
    check("R3 pad_out mux", pad_out, 32'h55AA00F0);
    check("R4 pad_oe open drain", pad_oe, 32'h0FF0FFF0);
    bus_write(5'd13, 32'h00000001);
    #1 check("R4 open drain pulls low", pad_oe, 32'h0FF0FFF1);
    bus_write(5'd29, 32'h0000FFFF);
    #1 check("R5 pad_pullup", pad_pullup, 32'hFFFF0000);
    bus_write(5'd0, 32'h00020000);
    #1 check("R3 pin back to gpio", pad_out, 32'h55A800F0);

    apply_reset();
    pad_in = 32'h12345678;
    @(posedge clk); @(posedge clk); @(negedge clk);
    peek(5'd15, rd); check("R6 two edges", rd, 32'h0);
    @(negedge clk);
    peek(5'd15, rd); check("R6 third edge", rd, 32'h12345678);
    check("R10 masked irq", {31'h0, irq}, 32'h0);
    bus_read(5'd19, rd); check("R8 rising edges pending", rd, 32'h12345678);
    bus_read(5'd19, rd); check("R9 cleared by read", rd, 32'h0);

    bus_write(5'd16, 32'h00000018);
    #1 check("R10 no pending", {31'h0, irq}, 32'h0);
    pad_in = 32'h12345670;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 irq on masked edge", {31'h0, irq}, 32'h1);
    peek(5'd19, rd); check("R8 falling edge pending", rd, 32'h00000008);
    bus_read(5'd19, rd);
    #1 check("R10 irq drops after clear", {31'h0, irq}, 32'h0);

    pad_in = 32'h12345660;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'd19;
    #1 check("R9 read before collision", bus_rdata, 32'h0);
    @(negedge clk);
    bus_sel = 1'b0;
    peek(5'd19, rd); check("R9 colliding edge kept", rd, 32'h00000010);
    check("R10 irq for kept edge", {31'h0, irq}, 32'h1);
    bus_read(5'd19, rd);

    bus_write(5'd8, 32'h00000100);
    pad_in = 32'h12347760;
    @(negedge clk);
    pad_in = 32'h12345660;
    repeat (5) @(negedge clk);
    peek(5'd15, rd); check("R7 pulses settle", rd, 32'h12345660);
    bus_read(5'd19, rd); check("R7 filtered pulse ignored, unfiltered seen", rd, 32'h00002000);
    pad_in = 32'h12345760;
    repeat (3) @(posedge clk);
    @(negedge clk);
    peek(5'd15, rd); check("R7 not yet accepted", rd, 32'h12345660);
    @(negedge clk);
    peek(5'd15, rd); check("R7 accepted one cycle later", rd, 32'h12345760);
    bus_read(5'd19, rd); check("R8 filtered edge pending", rd, 32'h00000100);

    done = 1;
    finish_run();
  end
endmodule